// File: doc/BRIEF.md
# Flash Command Sequencer with Sector Protection

This block is the command front end of a byte-wide parallel NOR flash array. It watches bus write cycles, recognises a two-write unlock prefix and the command byte that follows it, and turns program, sector erase and bulk erase requests into a one-cycle start strobe for the array. A request that would touch a protected sector is dropped without a start and without an error. The array itself is outside the block. It answers with a completion strobe and a failure strobe. The per-sector protection bits come in as a read-only vector.

A reset command (data F0h, with or without the unlock prefix) is handled according to the current state. It has no effect in read mode. It leaves ID/protection mode at once. It is ignored while a program or bulk erase runs. It aborts a sector erase. It clears a failure. Leaving a failure, or aborting a sector erase, passes through a recovery window of `RECOVER_CYC` clocks (at most 25 µs at `CLK_MHZ`) before read mode returns. The read port returns array data, a status byte, the device ID or the protection bits, depending on the mode.

Controller states: READ, PGM_ARM (waiting for the program operand), ERS_ARM (waiting for the erase selector), PGM_RUN, BULK_RUN, SECT_RUN, FAULT, IDPROT and RECOVER. Transitions:
- READ to PGM_ARM on A0h, to ERS_ARM on 80h, to IDPROT on 90h.
- PGM_ARM to PGM_RUN, or back to READ if the target sector is protected.
- ERS_ARM to SECT_RUN on 30h, to BULK_RUN on 10h, or back to READ if the request is blocked or the selector is unknown.
- Any RUN state to READ on completion and to FAULT on failure.
- SECT_RUN to RECOVER on reset.
- FAULT to RECOVER on reset.
- IDPROT to READ on reset.
- RECOVER to READ when the window expires.

The unlock decoder has three states: IDLE, HALF (first unlock write seen) and OPEN (prefix complete).

Top module: `flash_cmd_seq`

## Requirements
- R1: While and after `rst_n` is low, `mode` is 0 (read), `busy` is 0, `op_start` and `op_abort` are 0, and `rd_data` equals `arr_q`.
- R2: A command is the third write after data AAh at address 555h and data 55h at address AAAh. The command byte A0h arms a program, and the next write carries its address and data. The byte 80h arms an erase, and the next write is 30h (sector erase at that write's address) or 10h (bulk erase). The byte 90h enters ID/protection mode. The sector of an address is its top log2(SECTORS) bits.
- R3: A write that breaks the unlock prefix returns the decoder to idle. An unknown command byte or erase selector leaves the block in read mode. Neither starts anything.
- R4: An accepted operation raises `op_start` for one cycle in the cycle after its last write, with `op_kind` (0 program, 1 sector erase, 2 bulk erase), `op_addr` and `op_data`. `mode` is 3 (busy) from that cycle until the cycle of `op_done`, and the block is back in read mode one cycle later.
- R5: A program or sector erase whose sector has its protection bit set, or a bulk erase while any protection bit is set, gives no `op_start`, no error, and leaves the block in read mode.
- R6: A reset command is a write of F0h, plain or after the unlock prefix. In read mode it has no effect. In ID/protection mode (`mode` 2) it returns to read mode one cycle later.
- R7: A reset during a program or bulk erase is ignored: there is no `op_abort`, `mode` stays 3, and the operation ends on `op_done`.
- R8: A reset during a sector erase raises `op_abort` for one cycle and keeps `mode` at 3 for exactly `RECOVER_CYC` cycles before read mode returns.
- R9: `op_fail` during an operation moves the block to status mode (`mode` 1) with bit 5 of the status byte set. The block ignores all commands except reset, which leads through the `RECOVER_CYC`-cycle window to read mode.
- R10: `rd_data` is `arr_q` in mode 0. In modes 1 and 3 it is the status byte: bit 7 busy, bit 5 error, all other bits 0. In mode 2 it is `DEV_ID` when `rd_addr` is 0 and the protection bits (bit i for sector i) otherwise.
- R11: No write of any kind changes the protection bits seen through the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | ADDR_W | Bus read address |
| arr_q | input | 8 | Array read data |
| rd_data | output | 8 | Read data mux output |
| prot_bits | input | SECTORS | Per-sector protection bits, read-only |
| op_start | output | 1 | One-cycle operation start to the array |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 bulk erase |
| op_addr | output | ADDR_W | Target address of the operation |
| op_data | output | 8 | Program data |
| op_abort | output | 1 | One-cycle sector erase abort |
| op_done | input | 1 | Array completion strobe |
| op_fail | input | 1 | Array failure strobe |
| busy | output | 1 | High in mode 3 |
| mode | output | 2 | 0 read, 1 status, 2 ID/protection, 3 busy |

## Verification
The bench builds the block with `ADDR_W`=12, `SECTORS`=8 and `RECOVER_CYC`=5. With these values it can sweep every sector under several protection masks, for both program and sector erase, and compare each result with the mask bit worked out in the bench. The short recovery window lets the bench count every recovery cycle exactly. A behavioural array stub with a per-operation latency shows that the busy time is the stub latency plus one.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam logic [7:0] CMD_UNLK1  = 8'hAA;
    localparam logic [7:0] CMD_UNLK2  = 8'h55;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_IDPROT = 8'h90;
    localparam logic [7:0] SEL_BULK   = 8'h10;
    localparam logic [7:0] SEL_SECT   = 8'h30;
    localparam logic [11:0] UNLK_ADDR1 = 12'h555;
    localparam logic [11:0] UNLK_ADDR2 = 12'hAAA;

    typedef enum logic [1:0] {
        M_READ   = 2'd0,
        M_STATUS = 2'd1,
        M_IDPROT = 2'd2,
        M_BUSY   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        K_PROG = 2'd0,
        K_SECT = 2'd1,
        K_BULK = 2'd2
    } kind_e;
endpackage

// File: rtl/fcs_unlock.sv
module fcs_unlock
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              hold,
    output logic              cmd_valid,
    output logic              rst_cmd
);
    typedef enum logic [1:0] {U_IDLE, U_HALF, U_OPEN} ustate_e;
    ustate_e st_q, st_d;

    logic hit1, hit2;
    assign hit1 = (wr_addr[11:0] == UNLK_ADDR1) && (wr_data == CMD_UNLK1);
    assign hit2 = (wr_addr[11:0] == UNLK_ADDR2) && (wr_data == CMD_UNLK2);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= U_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d = U_IDLE;
        end else if (wr_en) begin
            unique case (st_q)
                U_IDLE:  st_d = hit1 ? U_HALF : U_IDLE;
                U_HALF:  st_d = hit2 ? U_OPEN : U_IDLE;
                U_OPEN:  st_d = U_IDLE;
                default: st_d = U_IDLE;
            endcase
        end
    end

    always_comb begin
        rst_cmd   = wr_en && !hold && (wr_data == CMD_RESET);
        cmd_valid = wr_en && !hold && (st_q == U_OPEN) && (wr_data != CMD_RESET);
    end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int RECOVER_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] START = CW'(RECOVER_CYC - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= START;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int SECTORS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               cmd_valid,
    input  logic               rst_cmd,
    input  logic [SECTORS-1:0] prot_bits,
    input  logic               op_done,
    input  logic               op_fail,
    input  logic               tmr_zero,
    output logic               hold,
    output logic               tmr_load,
    output logic [1:0]         mode,
    output logic               op_start,
    output logic [1:0]         op_kind,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [7:0]         op_data,
    output logic               op_abort
);
    localparam int SECT_W = $clog2(SECTORS);

    typedef enum logic [3:0] {
        S_READ, S_PGM_ARM, S_ERS_ARM, S_PGM_RUN, S_BULK_RUN,
        S_SECT_RUN, S_FAULT, S_IDPROT, S_RECOVER
    } cstate_e;
    cstate_e st_q, st_d;

    logic              launch, abort;
    kind_e             launch_kind;
    logic [SECT_W-1:0] sect_idx;
    logic              sect_locked, any_locked;

    assign sect_idx    = wr_addr[ADDR_W-1 -: SECT_W];
    assign sect_locked = prot_bits[sect_idx];
    assign any_locked  = |prot_bits;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_READ;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d        = st_q;
        launch      = 1'b0;
        launch_kind = K_PROG;
        abort       = 1'b0;
        unique case (st_q)
            S_READ: begin
                if (cmd_valid) begin
                    if (wr_data == CMD_PROG)        st_d = S_PGM_ARM;
                    else if (wr_data == CMD_ERASE)  st_d = S_ERS_ARM;
                    else if (wr_data == CMD_IDPROT) st_d = S_IDPROT;
                end
            end
            S_PGM_ARM: begin
                if (wr_en) begin
                    if (sect_locked) begin
                        st_d = S_READ;
                    end else begin
                        launch = 1'b1;
                        st_d   = S_PGM_RUN;
                    end
                end
            end
            S_ERS_ARM: begin
                if (wr_en) begin
                    st_d = S_READ;
                    if (wr_data == SEL_SECT && !sect_locked) begin
                        launch      = 1'b1;
                        launch_kind = K_SECT;
                        st_d        = S_SECT_RUN;
                    end else if (wr_data == SEL_BULK && !any_locked) begin
                        launch      = 1'b1;
                        launch_kind = K_BULK;
                        st_d        = S_BULK_RUN;
                    end
                end
            end
            S_PGM_RUN, S_BULK_RUN: begin
                if (op_fail)      st_d = S_FAULT;
                else if (op_done) st_d = S_READ;
            end
            S_SECT_RUN: begin
                if (op_fail)      st_d = S_FAULT;
                else if (op_done) st_d = S_READ;
                else if (rst_cmd) begin
                    abort = 1'b1;
                    st_d  = S_RECOVER;
                end
            end
            S_FAULT:   if (rst_cmd)  st_d = S_RECOVER;
            S_IDPROT:  if (rst_cmd)  st_d = S_READ;
            S_RECOVER: if (tmr_zero) st_d = S_READ;
            default:   st_d = S_READ;
        endcase
    end

    // outputs
    always_comb begin
        hold     = (st_q == S_PGM_ARM) || (st_q == S_ERS_ARM);
        tmr_load = (st_d == S_RECOVER) && (st_q != S_RECOVER);
        unique case (st_q)
            S_PGM_RUN, S_BULK_RUN, S_SECT_RUN, S_RECOVER: mode = M_BUSY;
            S_FAULT:  mode = M_STATUS;
            S_IDPROT: mode = M_IDPROT;
            default:  mode = M_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_abort <= 1'b0;
            op_kind  <= K_PROG;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= launch;
            op_abort <= abort;
            if (launch) begin
                op_kind <= launch_kind;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fcs_rdmux.sv
module fcs_rdmux
    import fcs_pkg::*;
#(
    parameter int         ADDR_W  = 12,
    parameter int         SECTORS = 8,
    parameter logic [7:0] DEV_ID  = 8'h5D
) (
    input  logic [1:0]         mode,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [7:0]         arr_q,
    input  logic [SECTORS-1:0] prot_bits,
    output logic [7:0]         rd_data
);
    logic [7:0] status_b;
    logic [7:0] prot_b;

    assign status_b = {mode == M_BUSY, 1'b0, mode == M_STATUS, 5'b0};
    assign prot_b   = 8'(prot_bits);

    always_comb begin
        unique case (mode)
            M_READ:   rd_data = arr_q;
            M_IDPROT: rd_data = (rd_addr == '0) ? DEV_ID : prot_b;
            default:  rd_data = status_b;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int         ADDR_W      = 12,
    parameter int         SECTORS     = 8,
    parameter int         CLK_MHZ     = 250,
    parameter int         RECOVER_CYC = 64,
    parameter logic [7:0] DEV_ID      = 8'h5D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [7:0]         arr_q,
    output logic [7:0]         rd_data,
    input  logic [SECTORS-1:0] prot_bits,
    output logic               op_start,
    output logic [1:0]         op_kind,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [7:0]         op_data,
    output logic               op_abort,
    input  logic               op_done,
    input  logic               op_fail,
    output logic               busy,
    output logic [1:0]         mode
);
    // recovery window limit in clocks (25 us at CLK_MHZ)
    localparam int RECOVER_LIMIT = 25 * CLK_MHZ;
    localparam int RECOVER_USE   = (RECOVER_CYC > RECOVER_LIMIT) ? RECOVER_LIMIT : RECOVER_CYC;

    logic hold, cmd_valid, rst_cmd, tmr_load, tmr_zero;

    fcs_unlock #(.ADDR_W(ADDR_W)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hold(hold), .cmd_valid(cmd_valid), .rst_cmd(rst_cmd)
    );

    fcs_ctrl #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_valid(cmd_valid), .rst_cmd(rst_cmd),
        .prot_bits(prot_bits), .op_done(op_done), .op_fail(op_fail),
        .tmr_zero(tmr_zero), .hold(hold), .tmr_load(tmr_load), .mode(mode),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .op_abort(op_abort)
    );

    fcs_timer #(.RECOVER_CYC(RECOVER_USE)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .zero(tmr_zero)
    );

    fcs_rdmux #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .DEV_ID(DEV_ID)) u_rdmux (
        .mode(mode), .rd_addr(rd_addr), .arr_q(arr_q),
        .prot_bits(prot_bits), .rd_data(rd_data)
    );

    assign busy = (mode == M_BUSY);
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter int SECTORS     = 8,
    parameter int RECOVER_CYC = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 mode,
    input logic                       op_start,
    input logic                       op_abort,
    input logic [1:0]                 op_kind,
    input logic [$clog2(SECTORS)-1:0] op_sect,
    input logic [SECTORS-1:0]         prot_bits
);
    localparam int RW = $clog2(RECOVER_CYC + 2);

    logic [SECTORS-1:0] prot_q;
    logic               trk_q;
    logic [RW-1:0]      win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
            trk_q  <= 1'b0;
            win_q  <= '0;
        end else begin
            prot_q <= prot_bits;
            if (op_abort) begin
                trk_q <= 1'b1;
                win_q <= RW'(1);
            end else if (trk_q && mode == M_BUSY) begin
                win_q <= win_q + 1'b1;
            end else begin
                trk_q <= 1'b0;
                win_q <= '0;
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_start && op_abort)); // R4
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> mode == M_BUSY); // R4
    AST_ABORT_SECT: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |-> op_kind == K_SECT); // R8
    AST_PROT_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind != K_BULK) |-> !prot_q[op_sect]); // R5
    AST_PROT_BULK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == K_BULK) |-> prot_q == '0); // R5
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_STATUS |=> (mode == M_STATUS || mode == M_BUSY)); // R9
    AST_IDPROT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_IDPROT |=> (mode == M_IDPROT || mode == M_READ)); // R6
    AST_RECOVER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q && mode == M_BUSY) |-> win_q < RW'(RECOVER_CYC)); // R8
endmodule

bind flash_cmd_seq fcs_checker #(.SECTORS(SECTORS), .RECOVER_CYC(RECOVER_USE)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .op_start(op_start),
    .op_abort(op_abort), .op_kind(op_kind),
    .op_sect(op_addr[ADDR_W-1 -: $clog2(SECTORS)]), .prot_bits(prot_bits)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    localparam int AW = 12;
    localparam int NS = 8;
    localparam int NR = 5;
    localparam logic [7:0] ID = 8'h5D;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, op_addr;
    logic [7:0] wr_data = '0, arr_q = 8'h3C, rd_data, op_data;
    logic [NS-1:0] prot_bits = '0;
    logic op_start, op_abort, busy;
    logic op_done = 1'b0, op_fail = 1'b0;
    logic [1:0] op_kind, mode;

    int total = 0, bad = 0, starts = 0, aborts = 0;
    int stub_lat = 3, stub_rem = 0;
    bit stub_act = 0, stub_fail = 0;
    logic [1:0] last_kind;
    logic [AW-1:0] last_addr;
    logic [7:0] last_data;

    always #2 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .SECTORS(NS), .CLK_MHZ(250), .RECOVER_CYC(NR), .DEV_ID(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .arr_q(arr_q), .rd_data(rd_data), .prot_bits(prot_bits),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .op_abort(op_abort), .op_done(op_done), .op_fail(op_fail), .busy(busy), .mode(mode)
    );

    always @(posedge clk) begin
        if (op_start) begin
            starts++;
            last_kind = op_kind;
            last_addr = op_addr;
            last_data = op_data;
        end
        if (op_abort) aborts++;
    end

    // behavioural array stub
    always @(negedge clk) begin
        op_done = 1'b0;
        op_fail = 1'b0;
        if (op_abort) begin
            stub_act = 0;
        end else if (op_start) begin
            stub_act = 1;
            stub_rem = stub_lat;
        end else if (stub_act) begin
            if (stub_rem == 1) begin
                stub_act = 0;
                if (stub_fail) op_fail = 1'b1;
                else           op_done = 1'b1;
            end else begin
                stub_rem--;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA);
        wr(12'hAAA, 8'h55);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (mode == 2'd3 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    int n, s0, a0;

    initial begin
        idle(3);
        chk("R1 mode", mode, 0);
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {op_start, op_abort}, 0);
        chk("R1 rd_data", rd_data, 8'h3C);
        rst_n = 1'b1;
        idle(2);
        chk("R10 read data", rd_data, 8'h3C);

        // R2 R4 R5: program and sector erase sweeps over all sectors and masks
        for (int m = 0; m < 4; m++) begin
            logic [7:0] masks [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
            prot_bits = masks[m];
            for (int k = 0; k < 2; k++) begin
                for (int s = 0; s < NS; s++) begin
                    logic [AW-1:0] ta;
                    bit exp_go;
                    ta = AW'((s << 9) | 12'h012);
                    exp_go = !masks[m][s];
                    stub_lat = 2 + s;
                    s0 = starts;
                    unlock();
                    if (k == 0) begin
                        wr(12'h555, 8'hA0);
                        wr(ta, 8'(8'h30 + s));
                    end else begin
                        wr(12'h555, 8'h80);
                        wr(ta, 8'h30);
                    end
                    if (exp_go) begin
                        if (m == 0 && s == 0 && k == 0) chk("R10 busy status", rd_data, 8'h80);
                        busy_len(n);
                        chk("R4 busy cycles", n, stub_lat + 1);
                        chk("R4 start count", starts - s0, 1);
                        chk("R4 kind", last_kind, k);
                        chk("R4 addr", last_addr, ta);
                        if (k == 0) chk("R4 data", last_data, 8'h30 + s);
                        chk("R4 back to read", mode, 0);
                    end else begin
                        idle(2);
                        chk("R5 no start", starts - s0, 0);
                        chk("R5 stays read", mode, 0);
                    end
                end
            end
        end

        // R5 bulk erase blocked, then R2 bulk accepted
        prot_bits = 8'h10;
        s0 = starts;
        unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'h10);
        idle(2);
        chk("R5 bulk blocked", starts - s0, 0);
        chk("R5 bulk mode", mode, 0);
        prot_bits = 8'h00;
        stub_lat = 4;
        unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'h10);
        busy_len(n);
        chk("R2 bulk busy", n, 5);
        chk("R2 bulk kind", last_kind, 2);

        // R3 broken prefix and unknown command
        s0 = starts;
        wr(12'h555, 8'hAA); wr(12'hAAB, 8'h55); wr(12'h555, 8'hA0);
        chk("R3 broken prefix mode", mode, 0);
        wr(12'h200, 8'h11);
        idle(2);
        chk("R3 broken prefix no start", starts - s0, 0);
        unlock(); wr(12'h555, 8'h77);
        chk("R3 unknown cmd", mode, 0);
        unlock(); wr(12'h555, 8'h80); wr(12'h200, 8'h44);
        idle(2);
        chk("R3 unknown selector", starts - s0, 0);
        chk("R3 unknown selector mode", mode, 0);

        // R6 reset in read mode
        wr(12'h000, 8'hF0);
        chk("R6 reset in read", mode, 0);

        // R7 reset ignored during program (plain) and bulk (prefixed)
        stub_lat = 12;
        a0 = aborts;
        unlock(); wr(12'h100, 8'hA0); wr(12'h100, 8'h5A);
        wr(12'h000, 8'hF0);
        chk("R7 program ignores reset", mode, 3);
        busy_len(n);
        chk("R7 program finishes", mode, 0);
        unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'h10);
        unlock(); wr(12'h000, 8'hF0);
        chk("R7 bulk ignores reset", mode, 3);
        busy_len(n);
        chk("R7 no abort", aborts - a0, 0);

        // R8 reset aborts sector erase, plain and prefixed
        for (int p = 0; p < 2; p++) begin
            stub_lat = 50;
            a0 = aborts;
            unlock(); wr(12'h600, 8'h80); wr(12'h600, 8'h30);
            if (p == 1) unlock();
            wr(12'h000, 8'hF0);
            busy_len(n);
            chk("R8 recovery cycles", n, NR);
            chk("R8 abort pulse", aborts - a0, 1);
            chk("R8 read after", mode, 0);
        end

        // R9 failure, command ignored, reset and recovery
        stub_lat = 3; stub_fail = 1;
        unlock(); wr(12'h300, 8'hA0); wr(12'h300, 8'h01);
        busy_len(n);
        stub_fail = 0;
        chk("R9 status mode", mode, 1);
        chk("R9 error bit", rd_data, 8'h20);
        s0 = starts;
        unlock(); wr(12'h555, 8'hA0); wr(12'h300, 8'h02);
        idle(2);
        chk("R9 commands ignored", mode, 1);
        chk("R9 no start", starts - s0, 0);
        wr(12'h000, 8'hF0);
        busy_len(n);
        chk("R9 recovery cycles", n, NR);
        chk("R9 read after", mode, 0);

        // R6 R10 R11 ID/protection mode
        prot_bits = 8'hC3;
        unlock(); wr(12'h555, 8'h90);
        chk("R6 idprot mode", mode, 2);
        rd_addr = 0; #1;
        chk("R10 device id", rd_data, ID);
        rd_addr = 1; #1;
        chk("R10 protection bits", rd_data, 8'hC3);
        s0 = starts;
        unlock(); wr(12'h555, 8'hA0); wr(12'h001, 8'h00); wr(12'h001, 8'hFF);
        idle(1);
        chk("R11 protection unchanged", rd_data, 8'hC3);
        chk("R11 no start", starts - s0, 0);
        chk("R6 idprot held", mode, 2);
        wr(12'h000, 8'hF0);
        chk("R6 reset leaves idprot", mode, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule